// File: doc/BRIEF.md
# Masked Vector Compress/Expand Unit

This unit performs the two order-preserving permutations that a vector pipeline uses for conditional code. It works on a vector of eight 32-bit elements and a mask with one bit for each element. In compress mode the elements whose mask bit is set are gathered to the low end of the result in ascending order. The unit also reports how many elements were gathered, so the next operation can use that value as its vector length. In expand mode the low source elements are spread, in order, onto the positions whose mask bit is set. Positions whose mask bit is clear take their value from an old-destination vector, which gives merge semantics.

One operation is accepted on any cycle where `in_valid` is high. Its result appears on the outputs on the following cycle, so a new operation can start every cycle. A two-state controller sequences the output. In state IDLE no result is presented. The transition IDLE→RESULT is taken when `in_valid` is seen. The self-loop RESULT→RESULT covers back-to-back operations. The transition RESULT→IDLE is taken on a cycle without `in_valid`. When no new operation arrives, the result vector and count keep their last values.

Top module: `cxu_top`

## Requirements
- R1: In compress mode (`in_op` = 0), result element k (bits [32k+31:32k]) equals the k-th source element, counted from element 0, whose mask bit is 1; mask bit i belongs to element i.
- R2: In compress mode, result elements at positions greater than or equal to the number of set mask bits are zero.
- R3: `out_count` equals the number of set bits in the mask, in both modes.
- R4: In expand mode (`in_op` = 1), the result element at the position of the k-th set mask bit (counting from bit 0) equals source element k.
- R5: In expand mode, a result element whose mask bit is 0 equals the same element of `in_old`.
- R6: An all-zero mask gives a count of 0, an all-zero result for compress, and a result equal to `in_old` for expand.
- R7: The result of an operation accepted on a clock edge is presented from that edge with `out_valid` high for one cycle. Back-to-back operations produce back-to-back results. On a cycle after an edge without `in_valid`, `out_valid` is low and the result vector and count hold their values.
- R8: While `rst_n` is low, `out_valid` is 0, the result vector is zero and the count is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operation is presented this cycle |
| in_op | input | 1 | 0 = compress, 1 = expand |
| in_mask | input | 8 | Per-element activity bits, bit i for element i |
| in_src | input | 256 | Source vector, element i in bits [32i+31:32i] |
| in_old | input | 256 | Prior destination contents, used by expand |
| out_valid | output | 1 | Result is presented this cycle |
| out_vec | output | 256 | Result vector |
| out_count | output | 4 | Number of set mask bits |

## Verification
Directed masks cover the extremes. An all-zero mask separates the zero-fill of compress from the merge of expand. An all-ones mask must turn both modes into the identity. A single set bit at the top or bottom position exposes off-by-one rank errors. Alternating and clustered masks show whether the order of elements is kept or reversed. Random masks and data in both modes, some issued back to back and some with idle gaps, test the full permutation, the hold behaviour and the single-cycle latency against reference functions in the bench.

// File: rtl/cxu_pkg.sv
package cxu_pkg;
    localparam int unsigned NUM_EL = 8;
    localparam int unsigned EL_W   = 32;
    localparam int unsigned CNT_W  = $clog2(NUM_EL + 1);
    localparam int unsigned IDX_W  = $clog2(NUM_EL);
    localparam int unsigned VEC_W  = NUM_EL * EL_W;

    typedef enum logic {
        OP_COMPRESS = 1'b0,
        OP_EXPAND   = 1'b1
    } cxu_op_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } cxu_state_e;
endpackage

// File: rtl/cxu_rank.sv
// Exclusive prefix population count of the mask: rank of each element
// among the active ones, plus the total number of active elements.
module cxu_rank #(
    parameter int unsigned NUM_EL = 8,
    localparam int unsigned CNT_W = $clog2(NUM_EL + 1)
) (
    input  logic [NUM_EL-1:0]       mask,
    output logic [NUM_EL*CNT_W-1:0] rank_flat,
    output logic [CNT_W-1:0]        total
);
    logic [CNT_W-1:0] run [NUM_EL+1];

    assign run[0] = '0;

    for (genvar i = 0; i < NUM_EL; i++) begin : g_run
        assign run[i+1] = run[i] + {{(CNT_W-1){1'b0}}, mask[i]};
        assign rank_flat[i*CNT_W +: CNT_W] = run[i];
    end

    assign total = run[NUM_EL];
endmodule

// File: rtl/cxu_compress.sv
// Packs active elements toward element 0; unused tail is zero.
module cxu_compress #(
    parameter int unsigned NUM_EL = 8,
    parameter int unsigned EL_W   = 32,
    localparam int unsigned CNT_W = $clog2(NUM_EL + 1)
) (
    input  logic [NUM_EL-1:0]       mask,
    input  logic [NUM_EL*CNT_W-1:0] rank_flat,
    input  logic [NUM_EL*EL_W-1:0]  src,
    output logic [NUM_EL*EL_W-1:0]  dst
);
    for (genvar j = 0; j < NUM_EL; j++) begin : g_slot
        logic [EL_W-1:0] acc;
        always_comb begin
            acc = '0;
            for (int i = 0; i < NUM_EL; i++) begin
                if (mask[i] && (rank_flat[i*CNT_W +: CNT_W] == CNT_W'(j))) begin
                    acc = acc | src[i*EL_W +: EL_W];
                end
            end
        end
        assign dst[j*EL_W +: EL_W] = acc;
    end
endmodule

// File: rtl/cxu_expand.sv
// Spreads low source elements onto active positions; inactive keep old.
module cxu_expand #(
    parameter int unsigned NUM_EL = 8,
    parameter int unsigned EL_W   = 32,
    localparam int unsigned CNT_W = $clog2(NUM_EL + 1),
    localparam int unsigned IDX_W = (NUM_EL > 1) ? $clog2(NUM_EL) : 1
) (
    input  logic [NUM_EL-1:0]       mask,
    input  logic [NUM_EL*CNT_W-1:0] rank_flat,
    input  logic [NUM_EL*EL_W-1:0]  src,
    input  logic [NUM_EL*EL_W-1:0]  old,
    output logic [NUM_EL*EL_W-1:0]  dst
);
    logic [EL_W-1:0] src_arr [NUM_EL];

    for (genvar i = 0; i < NUM_EL; i++) begin : g_unpack
        assign src_arr[i] = src[i*EL_W +: EL_W];
    end

    for (genvar j = 0; j < NUM_EL; j++) begin : g_slot
        logic [CNT_W-1:0] r;
        logic [IDX_W-1:0] sel;
        assign r   = rank_flat[j*CNT_W +: CNT_W];
        assign sel = r[IDX_W-1:0];
        assign dst[j*EL_W +: EL_W] = mask[j] ? src_arr[sel] : old[j*EL_W +: EL_W];
    end
endmodule

// File: rtl/cxu_top.sv
module cxu_top
    import cxu_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    in_op,
    input  logic [NUM_EL-1:0]       in_mask,
    input  logic [VEC_W-1:0]        in_src,
    input  logic [VEC_W-1:0]        in_old,
    output logic                    out_valid,
    output logic [VEC_W-1:0]        out_vec,
    output logic [CNT_W-1:0]        out_count
);
    cxu_state_e              state_q, state_d;
    logic [NUM_EL*CNT_W-1:0] rank_flat;
    logic [CNT_W-1:0]        total;
    logic [VEC_W-1:0]        cmp_vec;
    logic [VEC_W-1:0]        exp_vec;
    logic [VEC_W-1:0]        sel_vec;
    cxu_op_e                 op;

    assign op = cxu_op_e'(in_op);

    cxu_rank #(.NUM_EL(NUM_EL)) u_rank (
        .mask      (in_mask),
        .rank_flat (rank_flat),
        .total     (total)
    );

    cxu_compress #(.NUM_EL(NUM_EL), .EL_W(EL_W)) u_compress (
        .mask      (in_mask),
        .rank_flat (rank_flat),
        .src       (in_src),
        .dst       (cmp_vec)
    );

    cxu_expand #(.NUM_EL(NUM_EL), .EL_W(EL_W)) u_expand (
        .mask      (in_mask),
        .rank_flat (rank_flat),
        .src       (in_src),
        .old       (in_old),
        .dst       (exp_vec)
    );

    always_comb begin
        unique case (op)
            OP_COMPRESS: sel_vec = cmp_vec;
            OP_EXPAND:   sel_vec = exp_vec;
            default:     sel_vec = cmp_vec;
        endcase
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = in_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = in_valid ? ST_RESULT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_vec   <= '0;
            out_count <= '0;
        end else if (in_valid) begin
            out_vec   <= sel_vec;
            out_count <= total;
        end
    end

    assign out_valid = (state_q == ST_RESULT);

    // ---------------- assertions ----------------
    AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R7
    AST_IDLE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_vec) && $stable(out_count))); // R7
    AST_COUNT_POPCNT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (32'(out_count) == $countones($past(in_mask)))); // R3
    AST_EMPTY_COMPRESS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_op && in_mask == '0) |=> (out_vec == '0)); // R6

    for (genvar j = 0; j < NUM_EL; j++) begin : g_chk
        AST_EXPAND_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_op && !in_mask[j]) |=>
            (out_vec[j*EL_W +: EL_W] == $past(in_old[j*EL_W +: EL_W]))); // R5
        AST_COMPRESS_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !in_op && ($countones(in_mask) <= j)) |=>
            (out_vec[j*EL_W +: EL_W] == '0)); // R2
    end
endmodule

// File: tb/cxu_top_bench.sv
module cxu_top_bench;
    localparam int N  = 8;
    localparam int W  = 32;
    localparam int VW = N * W;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic          in_op;
    logic [N-1:0]  in_mask;
    logic [VW-1:0] in_src;
    logic [VW-1:0] in_old;
    logic          out_valid;
    logic [VW-1:0] out_vec;
    logic [3:0]    out_count;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    cxu_top u_cxu_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_op     (in_op),
        .in_mask   (in_mask),
        .in_src    (in_src),
        .in_old    (in_old),
        .out_valid (out_valid),
        .out_vec   (out_vec),
        .out_count (out_count)
    );

    function automatic logic [VW-1:0] ref_result(input logic op, input logic [N-1:0] m,
                                                 input logic [VW-1:0] s, input logic [VW-1:0] o);
        logic [VW-1:0] r;
        int k = 0;
        r = op ? o : '0;
        for (int i = 0; i < N; i++) begin
            if (m[i]) begin
                if (op) r[i*W +: W] = s[k*W +: W];
                else    r[k*W +: W] = s[i*W +: W];
                k++;
            end
        end
        return r;
    endfunction

    function automatic logic [3:0] ref_count(input logic [N-1:0] m);
        int c = 0;
        for (int i = 0; i < N; i++) c += int'(m[i]);
        return 4'(c);
    endfunction

    task automatic check_vec(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: vec actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_val(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [VW-1:0] rnd_vec();
        logic [VW-1:0] v;
        for (int i = 0; i < N; i++) v[i*W +: W] = $urandom;
        return v;
    endfunction

    // drive at negedge, sample at next negedge (one register stage)
    task automatic do_op(input string req, input logic op, input logic [N-1:0] m,
                         input logic [VW-1:0] s, input logic [VW-1:0] o, input bit keep_valid);
        in_valid = 1'b1; in_op = op; in_mask = m; in_src = s; in_old = o;
        @(negedge clk);
        if (!keep_valid) in_valid = 1'b0;
        check_val({req, " valid R7"}, int'(out_valid), 1);
        check_val({req, " count R3"}, int'(out_count), int'(ref_count(m)));
        check_vec(req, out_vec, ref_result(op, m, s, o));
    endtask

    task automatic idle_check();
        logic [VW-1:0] pv;
        logic [3:0] pc;
        pv = out_vec; pc = out_count;
        in_valid = 1'b0;
        in_src = rnd_vec(); in_old = rnd_vec(); in_mask = N'($urandom);
        @(negedge clk);
        check_val("R7 idle valid", int'(out_valid), 0);
        check_vec("R7 idle hold vec", out_vec, pv);
        check_val("R7 idle hold count", int'(out_count), int'(pc));
    endtask

    initial begin : watchdog
        #(4 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [VW-1:0] s, o;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; in_valid = 1'b0; in_op = 1'b0; in_mask = '0;
        in_src = rnd_vec(); in_old = rnd_vec();
        repeat (3) @(negedge clk);
        // R8 reset state
        check_val("R8 reset valid", int'(out_valid), 0);
        check_vec("R8 reset vec", out_vec, '0);
        check_val("R8 reset count", int'(out_count), 0);
        rst_n = 1'b1;
        @(negedge clk);

        s = rnd_vec(); o = rnd_vec();
        do_op("R6 compress empty", 1'b0, 8'h00, s, o, 0);
        do_op("R6 expand empty",   1'b1, 8'h00, s, o, 0);
        do_op("R1 compress full",  1'b0, 8'hFF, s, o, 0);
        do_op("R4 expand full",    1'b1, 8'hFF, s, o, 0);
        do_op("R1 compress top",   1'b0, 8'h80, s, o, 0);
        do_op("R2 compress bottom",1'b0, 8'h01, s, o, 0);
        do_op("R4 expand top",     1'b1, 8'h80, s, o, 0);
        do_op("R5 expand bottom",  1'b1, 8'h01, s, o, 0);
        do_op("R1 compress alt",   1'b0, 8'hAA, s, o, 0);
        do_op("R4 expand alt",     1'b1, 8'h55, s, o, 0);
        idle_check();
        // back-to-back operations
        do_op("R7 b2b first",  1'b0, 8'h3C, rnd_vec(), rnd_vec(), 1);
        do_op("R7 b2b second", 1'b1, 8'hC3, rnd_vec(), rnd_vec(), 1);
        do_op("R7 b2b third",  1'b0, 8'h96, rnd_vec(), rnd_vec(), 0);
        idle_check();

        for (int it = 0; it < 400; it++) begin
            logic op_r;
            logic [N-1:0] m_r;
            op_r = 1'($urandom);
            m_r  = N'($urandom);
            if (op_r) do_op("R4 R5 expand random", 1'b1, m_r, rnd_vec(), rnd_vec(), ($urandom % 3) != 0);
            else      do_op("R1 R2 compress random", 1'b0, m_r, rnd_vec(), rnd_vec(), ($urandom % 3) != 0);
            if (($urandom % 5) == 0) begin
                in_valid = 1'b0;
                @(negedge clk);
                idle_check();
            end
        end
        in_valid = 1'b0;
        @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule